// File: doc/BRIEF.md
# Packed Vector Multiply with Shift, Rounding and Narrowing

This block multiplies two packed vectors lane by lane and narrows each product back to the lane width. With the default parameters each 128-bit operand holds eight signed 16-bit lanes. Each lane forms a full 32-bit signed product. The product is then shifted right arithmetically by 0 to 15 places. The bits shifted out are resolved by a selectable rounding rule. Finally the value is either clamped to the signed 16-bit range or cut to its low 16 bits. The results are registered and appear one clock after the input strobe.

The rounding rule comes from a 3-bit select that travels with each operation. One select code defers to a small mode register that is written through its own strobe. This lets a sequence of operations share one rounding rule that is set up in advance. Selecting truncating narrowing with toward-zero rounding gives the conventional default behaviour. Each lane works on its own, and no carry crosses a lane boundary.

Top module: `simd_mul_round`

## Requirements
- R1: While reset is held and right after it is released, `out_valid` is 0 and `res` is all zeros. The mode register resets to toward-zero (code 3).
- R2: Lane i occupies bits [16i+15:16i] of `op_a`, `op_b` and `res`, and the lanes do not affect each other. With `shift` = 0 no bits are discarded, so every rounding code yields the exact signed product before narrowing.
- R3: Code 0 (floor) rounds the shifted value toward minus infinity.
- R4: Code 1 (ceiling) rounds the shifted value toward plus infinity.
- R5: Code 2 rounds away from zero. Code 3 rounds toward zero. `sat_en` = 0 together with code 3 is the default behaviour.
- R6: Code 4 rounds to the nearest value and resolves an exact half away from zero. Code 5 rounds to the nearest value and resolves an exact half toward zero. In both cases the sign of the product decides the direction of a tie.
- R7: Code 6 rounds to the nearest value and resolves an exact half toward the even result.
- R8: Code 7 takes the rounding rule from the mode register. The register is loaded from `cfg_mode` on a clock edge where `cfg_we` is 1, and it governs operations presented on later edges. A stored value of 7 acts as code 3.
- R9: Rounding is applied to the full-precision shifted value before narrowing. With `sat_en` = 1 the result is clamped to the range [-32768, 32767]. With `sat_en` = 0 the low 16 bits of the rounded value are kept.
- R10: `out_valid` equals `in_valid` delayed by exactly one clock. `res` changes only on a clock edge where `in_valid` is 1, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| op_a | input | 128 | Packed first operand, signed lanes |
| op_b | input | 128 | Packed second operand, signed lanes |
| shift | input | 4 | Right-shift amount applied to each product |
| rnd_mode | input | 3 | Rounding code (7 = use mode register) |
| sat_en | input | 1 | 1 = clamp, 0 = keep low bits |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_mode | input | 3 | Value written to the mode register |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| res | output | 128 | Packed narrowed results |

## Verification
The bench builds the block with its default parameters: eight 16-bit lanes and a 4-bit shift. With these values every shift from 0 to 15 and the full product range are reachable, including the single overflowing product -32768 x -32768. Random operands are mixed with small operands so that exact-half ties occur often at small shifts. Directed vectors place positive and negative ties side by side, test the mode register before and after it is written, and push both saturation limits.

// File: rtl/simd_mul_round.sv
module simd_mul_round #(
  parameter int LANES = 8,
  parameter int EW    = 16,
  parameter int SHW   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [LANES*EW-1:0]   op_a,
  input  logic [LANES*EW-1:0]   op_b,
  input  logic [SHW-1:0]        shift,
  input  logic [2:0]            rnd_mode,
  input  logic                  sat_en,
  input  logic                  cfg_we,
  input  logic [2:0]            cfg_mode,
  output logic                  out_valid,
  output logic [LANES*EW-1:0]   res
);
  localparam int VW = LANES * EW;
  localparam int PW = 2 * EW;
  localparam int RW = PW + 1;
  localparam logic [2:0] M_TZ  = 3'd3;
  localparam logic [2:0] M_DYN = 3'd7;
  localparam logic signed [RW-1:0] SMAX = RW'((1 << (EW - 1)) - 1);
  localparam logic signed [RW-1:0] SMIN = -SMAX - RW'(1);

  logic [2:0]    cfg_q;
  logic [2:0]    eff_mode;
  logic [VW-1:0] nxt;

  function automatic logic [EW-1:0] lane_op(
    input logic signed [EW-1:0] a,
    input logic signed [EW-1:0] b,
    input logic [SHW-1:0]       sh,
    input logic [2:0]           md,
    input logic                 sat
  );
    logic signed [PW-1:0] p;
    logic signed [RW-1:0] q, r;
    logic [PW-1:0] mask, rem, half;
    logic inexact, tie, gt, neg, up;
    p       = a * b;
    q       = $signed({p[PW-1], p}) >>> sh;
    mask    = (PW'(1) << sh) - PW'(1);
    rem     = p & mask;
    half    = (PW'(1) << sh) >> 1;
    inexact = rem != '0;
    tie     = (sh != '0) && (rem == half);
    gt      = rem > half;
    neg     = p[PW-1];
    case (md)
      3'd0:    up = 1'b0;
      3'd1:    up = inexact;
      3'd2:    up = inexact & ~neg;
      3'd4:    up = gt | (tie & ~neg);
      3'd5:    up = gt | (tie & neg);
      3'd6:    up = gt | (tie & q[0]);
      default: up = inexact & neg;
    endcase
    r = q + $signed({{(RW-1){1'b0}}, up});
    if (sat && r > SMAX)      lane_op = SMAX[EW-1:0];
    else if (sat && r < SMIN) lane_op = SMIN[EW-1:0];
    else                      lane_op = r[EW-1:0];
  endfunction

  assign eff_mode = (rnd_mode != M_DYN) ? rnd_mode :
                    (cfg_q == M_DYN)    ? M_TZ : cfg_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign nxt[l*EW +: EW] = lane_op(op_a[l*EW +: EW], op_b[l*EW +: EW],
                                     shift, eff_mode, sat_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res       <= '0;
      cfg_q     <= M_TZ;
    end else begin
      out_valid <= in_valid;
      if (in_valid) res <= nxt;
      if (cfg_we) cfg_q <= cfg_mode;
    end
  end
endmodule

module simd_mul_round_chk #(
  parameter int LANES = 8,
  parameter int EW    = 16,
  parameter int SHW   = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [LANES*EW-1:0] op_a,
  input logic [LANES*EW-1:0] op_b,
  input logic [SHW-1:0]      shift,
  input logic                sat_en,
  input logic                out_valid,
  input logic [LANES*EW-1:0] res
);
  logic signed [2*EW-1:0] p0;
  logic corner;
  assign p0 = $signed(op_a[EW-1:0]) * $signed(op_b[EW-1:0]);
  assign corner = op_a[EW-1:0] == {1'b1, {(EW-1){1'b0}}} &&
                  op_b[EW-1:0] == {1'b1, {(EW-1){1'b0}}};

  a_r10_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r10_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res));
  a_r2_exact_lane0: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && shift == '0 && !sat_en) |=> res[EW-1:0] == $past(p0[EW-1:0]));
  a_r9_clamp_top: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sat_en && shift == '0 && corner) |=> res[EW-1:0] == {1'b0, {(EW-1){1'b1}}});
endmodule

bind simd_mul_round simd_mul_round_chk #(.LANES(LANES), .EW(EW), .SHW(SHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .shift(shift), .sat_en(sat_en), .out_valid(out_valid), .res(res)
);

// File: tb/simd_mul_round_tb.sv
module simd_mul_round_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [127:0] op_a = '0, op_b = '0;
  logic [3:0] shift = '0;
  logic [2:0] rnd_mode = '0;
  logic sat_en = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_mode = '0;
  logic out_valid;
  logic [127:0] res;

  int checks = 0, errors = 0, cycles = 0;
  logic [2:0] cfg_m = 3'd3;
  logic [127:0] last_res;

  simd_mul_round u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a),
    .op_b(op_b), .shift(shift), .rnd_mode(rnd_mode), .sat_en(sat_en), .cfg_we(cfg_we),
    .cfg_mode(cfg_mode), .out_valid(out_valid), .res(res));

  always #5 clk = ~clk;

  function automatic logic [15:0] model(input logic signed [15:0] a, b,
      input int sh, input logic [2:0] md, input logic sat);
    longint p, d, q, rem, r;
    logic neg;
    p = longint'(a) * longint'(b);
    d = longint'(1) << sh;
    q = p / d;
    if ((p % d) != 0 && p < 0) q = q - 1;
    rem = p - q * d;
    neg = p < 0;
    case (md)
      3'd0: r = q;
      3'd1: r = (rem != 0) ? q + 1 : q;
      3'd2: r = (rem != 0 && !neg) ? q + 1 : q;
      3'd4: r = (2*rem > d || (2*rem == d && !neg)) ? q + 1 : q;
      3'd5: r = (2*rem > d || (2*rem == d && neg)) ? q + 1 : q;
      3'd6: r = (2*rem > d || (2*rem == d && q[0])) ? q + 1 : q;
      default: r = (rem != 0 && neg) ? q + 1 : q;
    endcase
    if (sat && r > 32767) r = 32767;
    if (sat && r < -32768) r = -32768;
    return r[15:0];
  endfunction

  function automatic logic [127:0] model_vec(input logic [127:0] a, b,
      input int sh, input logic [2:0] md, input logic sat);
    logic [127:0] v;
    logic [2:0] e;
    e = (md != 3'd7) ? md : (cfg_m == 3'd7 ? 3'd3 : cfg_m);
    for (int l = 0; l < 8; l++) v[l*16 +: 16] = model(a[l*16 +: 16], b[l*16 +: 16], sh, e, sat);
    return v;
  endfunction

  task automatic check(input string tag, input logic [127:0] got, exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic op(input logic [127:0] a, b, input logic [3:0] sh,
      input logic [2:0] md, input logic s, input string tag);
    logic [127:0] exp;
    exp = model_vec(a, b, int'(sh), md, s);
    op_a = a; op_b = b; shift = sh; rnd_mode = md; sat_en = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " out_valid R10"}, {127'd0, out_valid}, 128'd1);
    check(tag, res, exp);
    last_res = res;
  endtask

  task automatic cfg_write(input logic [2:0] v);
    cfg_we = 1'b1; cfg_mode = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_m = v;
  endtask

  function automatic logic [127:0] lane0(input logic [15:0] v);
    return {112'd0, v};
  endfunction

  function automatic string tag_of(input logic [2:0] md);
    case (md)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2, 3'd3: return "R5";
      3'd4, 3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [127:0] rand_vec();
    logic [127:0] v;
    for (int l = 0; l < 8; l++)
      v[l*16 +: 16] = ($urandom % 4 == 0) ? 16'($signed(int'($urandom % 33) - 16)) : 16'($urandom);
    return v;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset res", res, 128'd0);
    check("R1 reset valid", {127'd0, out_valid}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release valid", {127'd0, out_valid}, 128'd0);

    // R2: exact products with shift 0 in all modes, lanes independent
    for (int m = 0; m < 7; m++)
      op({16'd7, 16'hfffd, 16'd300, 16'h8000, 16'd1, 16'hffff, 16'd12, 16'h8000},
         {16'd9, 16'd5, 16'd300, 16'd1, 16'h7fff, 16'hffff, 16'hfff4, 16'h8000},
         4'd0, 3'(m), 1'b0, "R2 exact");
    check("R2 lane1 literal", {112'd0, last_res[31:16]}, lane0(16'hff70));

    // ties: 3/2, -3/2, 5/2
    op(lane0(16'd3), lane0(16'd1), 4'd1, 3'd4, 1'b0, "R6 half away +");
    check("R6 literal +1.5 -> 2", last_res, lane0(16'd2));
    op(lane0(16'hfffd), lane0(16'd1), 4'd1, 3'd4, 1'b0, "R6 half away -");
    check("R6 literal -1.5 -> -2", last_res, lane0(16'hfffe));
    op(lane0(16'd3), lane0(16'd1), 4'd1, 3'd5, 1'b0, "R6 half toward +");
    op(lane0(16'hfffd), lane0(16'd1), 4'd1, 3'd5, 1'b0, "R6 half toward -");
    check("R6 literal -1.5 -> -1", last_res, lane0(16'hffff));
    op(lane0(16'd5), lane0(16'd1), 4'd1, 3'd6, 1'b0, "R7 even 2.5");
    check("R7 literal 2.5 -> 2", last_res, lane0(16'd2));
    op(lane0(16'd7), lane0(16'd1), 4'd1, 3'd6, 1'b0, "R7 even 3.5");
    check("R7 literal 3.5 -> 4", last_res, lane0(16'd4));
    op(lane0(16'hfffb), lane0(16'd1), 4'd2, 3'd0, 1'b0, "R3 floor -1.25");
    check("R3 literal -> -2", last_res, lane0(16'hfffe));
    op(lane0(16'hfffb), lane0(16'd1), 4'd2, 3'd1, 1'b0, "R4 ceil -1.25");
    check("R4 literal -> -1", last_res, lane0(16'hffff));
    op(lane0(16'hfffb), lane0(16'd1), 4'd2, 3'd2, 1'b0, "R5 away -1.25");
    op(lane0(16'hfffb), lane0(16'd1), 4'd2, 3'd3, 1'b0, "R5 toward -1.25");

    // R10: idle cycle keeps result and drops valid
    @(negedge clk);
    check("R10 hold res", res, last_res);
    check("R10 valid low", {127'd0, out_valid}, 128'd0);

    // R8: dynamic mode
    op(lane0(16'hfffd), lane0(16'd1), 4'd1, 3'd7, 1'b0, "R8 reset cfg toward zero");
    check("R8 literal -> -1", last_res, lane0(16'hffff));
    cfg_write(3'd0);
    op(lane0(16'hfffd), lane0(16'd1), 4'd1, 3'd7, 1'b0, "R8 cfg floor");
    check("R8 literal -> -2", last_res, lane0(16'hfffe));
    cfg_write(3'd7);
    op(lane0(16'hfffd), lane0(16'd1), 4'd1, 3'd7, 1'b0, "R8 cfg 7 as toward zero");
    check("R8 literal code7 -> -1", last_res, lane0(16'hffff));

    // R9: saturation corners
    op(lane0(16'h8000), lane0(16'h8000), 4'd0, 3'd3, 1'b1, "R9 sat top");
    check("R9 literal 32767", last_res, lane0(16'h7fff));
    op(lane0(16'h8000), lane0(16'h7fff), 4'd0, 3'd3, 1'b1, "R9 sat bottom");
    check("R9 literal -32768", last_res, lane0(16'h8000));
    op(lane0(16'h8000), lane0(16'h8000), 4'd0, 3'd3, 1'b0, "R9 trunc wrap");
    check("R9 literal wrap 0", last_res, lane0(16'h0000));
    op(lane0(16'h7fff), lane0(16'h7fff), 4'd15, 3'd1, 1'b1, "R9 shift15 ceil");

    // random mix
    for (int i = 0; i < 1500; i++) begin
      logic [2:0] md;
      if ($urandom % 20 == 0) cfg_write(3'($urandom));
      md = 3'($urandom);
      op(rand_vec(), rand_vec(), 4'($urandom), md, 1'($urandom), tag_of(md));
      if ($urandom % 8 == 0) begin
        @(negedge clk);
        check("R10 random hold", res, last_res);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule